// File: doc/BRIEF.md
# Suspend-Time Interrupt Edge Recorder

The block sits between a set of external interrupt lines and a parent interrupt controller. In normal operation it is transparent: each line is normalised by its programmed polarity and reaches the parent two clock cycles later. Before the system enters a low-power state, software arms the unit in edge-recording mode. Each active edge on an unmasked, edge-configured line is then caught in a pending bit, and the parent sees nothing. On wake-up, software issues a flush. The flush replays every pending line to the parent as a one-cycle pulse and empties the record. Software then disarms the unit.

Each line has three attributes: mask, sensitivity and polarity. Each attribute is reached through its own pair of 32-bit register banks. Writing ones to the set bank raises the selected bits, and writing ones to the clear bank lowers them. Reading either bank of a pair returns the current attribute word. The line count is a parameter of up to 512 lines.

Top module: `irq_edge_recorder`

## Requirements
- R1: After reset, every line is masked, edge-sensitive and of polarity 1, and the control register reads 0.
- R2: A write to a set bank raises exactly the bits written as 1 and leaves the other bits unchanged. The set banks are mask 0x0C0, sensitivity 0x180 and polarity 0x240. Line n lives in the word at bank + (n/32)*4, at bit n%32.
- R3: A write to a clear bank lowers exactly the bits written as 1. The clear banks are mask 0x100, sensitivity 0x1C0 and polarity 0x280. Reading the set or the clear address of a pair returns the same attribute word.
- R4: While bit 0 (enable) of the control register at 0x300 is 0, irq_out equals irq_in two cycles earlier for lines of polarity 1, and its inverse for lines of polarity 0.
- R5: With enable and bit 1 (edge mode) both set, a line that is unmasked (mask 0) and edge-sensitive (sensitivity 0) records its active edge: rising for polarity 1, falling for polarity 0.
- R6: A line whose mask bit is 1 never records an edge.
- R7: A line whose sensitivity bit is 1 (level) never records an edge.
- R8: No edge is recorded unless enable and edge mode are both set. While enable is set, irq_out stays 0 outside flush pulses.
- R9: A control write with bit 2 set raises irq_out for exactly one cycle, in the cycle after the write, on every line pending at that write, and clears those pending bits. An immediate second flush produces no pulse.
- R10: Control bits 0 and 1 read back as written. Bit 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | LINES | External interrupt lines (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | LINES | Lines toward the parent controller |

## Verification
The transparent path is driven with random line patterns under two polarity settings. These patterns separate a correct inversion from a missing one, and expose a wrong synchroniser depth. Recording is first tried with a directed burst that toggles a masked line, a level line, a falling-active line, a rising-active line and a line in the second, partial word. A single flushed value then shows which filters act. Recording is also tried with enable or edge mode alone, and finally with random traffic compared each cycle against a behavioural model. This last pattern catches double recording, lost edges and flush pulses that last too long or too short.

// File: rtl/irq_edge_recorder.sv
module irq_edge_recorder #(
  parameter int LINES = 512,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [LINES-1:0] irq_out
);
  localparam int WORDS = (LINES + 31) / 32;
  localparam int PADW  = WORDS * 32;
  localparam logic [AW-1:0] A_MSET = AW'(12'h0C0);
  localparam logic [AW-1:0] A_MCLR = AW'(12'h100);
  localparam logic [AW-1:0] A_SSET = AW'(12'h180);
  localparam logic [AW-1:0] A_SCLR = AW'(12'h1C0);
  localparam logic [AW-1:0] A_PSET = AW'(12'h240);
  localparam logic [AW-1:0] A_PCLR = AW'(12'h280);
  localparam logic [AW-1:0] A_CTRL = AW'(12'h300);

  function automatic logic in_bank(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (a >= b) && (a < b + AW'(WORDS * 4)) && (a[1:0] == 2'b00);
  endfunction

  function automatic int widx(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return int'((a - b) >> 2);
  endfunction

  function automatic logic [LINES-1:0] spread(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                               input logic [31:0] d);
    logic [PADW-1:0] w;
    w = '0;
    if (in_bank(a, b)) w[widx(a, b)*32 +: 32] = d;
    return w[LINES-1:0];
  endfunction

  function automatic logic [31:0] pick(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                       input logic [LINES-1:0] v);
    logic [PADW-1:0] w;
    w = PADW'(v);
    return w[widx(a, b)*32 +: 32];
  endfunction

  logic [LINES-1:0] mask, sens, pol;
  logic [LINES-1:0] s1, s2, norm_q, pending, flush_vec;
  logic             en, edge_md;

  wire              ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  wire              flush_wr = ctrl_wr && reg_wdata[2];
  wire [LINES-1:0]  norm     = ~(s2 ^ pol);
  wire [LINES-1:0]  rec      = norm & ~norm_q & ~mask & ~sens & {LINES{en & edge_md}};
  wire [LINES-1:0]  wset_m   = reg_wr ? spread(reg_addr, A_MSET, reg_wdata) : '0;
  wire [LINES-1:0]  wclr_m   = reg_wr ? spread(reg_addr, A_MCLR, reg_wdata) : '0;
  wire [LINES-1:0]  wset_s   = reg_wr ? spread(reg_addr, A_SSET, reg_wdata) : '0;
  wire [LINES-1:0]  wclr_s   = reg_wr ? spread(reg_addr, A_SCLR, reg_wdata) : '0;
  wire [LINES-1:0]  wset_p   = reg_wr ? spread(reg_addr, A_PSET, reg_wdata) : '0;
  wire [LINES-1:0]  wclr_p   = reg_wr ? spread(reg_addr, A_PCLR, reg_wdata) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= '1;
      sens      <= '0;
      pol       <= '1;
      en        <= 1'b0;
      edge_md   <= 1'b0;
      s1        <= '0;
      s2        <= '0;
      norm_q    <= '0;
      pending   <= '0;
      flush_vec <= '0;
    end else begin
      mask      <= (mask | wset_m) & ~wclr_m;
      sens      <= (sens | wset_s) & ~wclr_s;
      pol       <= (pol  | wset_p) & ~wclr_p;
      if (ctrl_wr) begin
        en      <= reg_wdata[0];
        edge_md <= reg_wdata[1];
      end
      s1        <= irq_in;
      s2        <= s1;
      norm_q    <= norm;
      flush_vec <= flush_wr ? pending : '0;
      pending   <= flush_wr ? rec : (pending | rec);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if      (in_bank(reg_addr, A_MSET)) reg_rdata = pick(reg_addr, A_MSET, mask);
    else if (in_bank(reg_addr, A_MCLR)) reg_rdata = pick(reg_addr, A_MCLR, mask);
    else if (in_bank(reg_addr, A_SSET)) reg_rdata = pick(reg_addr, A_SSET, sens);
    else if (in_bank(reg_addr, A_SCLR)) reg_rdata = pick(reg_addr, A_SCLR, sens);
    else if (in_bank(reg_addr, A_PSET)) reg_rdata = pick(reg_addr, A_PSET, pol);
    else if (in_bank(reg_addr, A_PCLR)) reg_rdata = pick(reg_addr, A_PCLR, pol);
    else if (reg_addr == A_CTRL)        reg_rdata = {30'b0, edge_md, en};
  end

  assign irq_out = en ? flush_vec : norm;
endmodule

module irq_edge_recorder_sva #(parameter int LINES = 512) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             edge_md,
  input logic             flush_wr,
  input logic [LINES-1:0] mask,
  input logic [LINES-1:0] sens,
  input logic [LINES-1:0] pending,
  input logic [LINES-1:0] irq_out
);
  p_masked_no_record_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~$past(pending) & $past(mask)) == '0);
  p_level_no_record_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~$past(pending) & $past(sens)) == '0);
  p_disarmed_no_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en && edge_md) |-> (pending & ~$past(pending)) == '0);
  p_quiet_when_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(flush_wr)) |-> irq_out == '0);
endmodule

bind irq_edge_recorder irq_edge_recorder_sva #(.LINES(LINES)) u_sva (
  .clk(clk), .rst_n(rst_n), .en(en), .edge_md(edge_md), .flush_wr(flush_wr),
  .mask(mask), .sens(sens), .pending(pending), .irq_out(irq_out)
);

// File: tb/irq_edge_recorder_bench.sv
module irq_edge_recorder_bench;
  localparam int L = 40;
  localparam logic [L-1:0] IDLE = 40'h03_0000_00F0;

  logic          clk = 0, rst_n = 0, reg_wr = 0;
  logic [L-1:0]  irq_in = '0, irq_out;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  int            checks = 0, fails = 0;
  bit            done = 0;
  string         tag = "R4";

  logic [L-1:0]  m_mask = '1, m_sens = '0, m_pol = '1, m_s1 = '0, m_s2 = '0, m_nq = '0;
  logic [L-1:0]  m_pend = '0, m_flush = '0;
  logic          m_en = 0, m_edge = 0;

  irq_edge_recorder #(.LINES(L), .AW(12)) u_irq_edge_recorder (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  always #4 clk = ~clk;

  task automatic chk(input string t, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  function automatic logic [L-1:0] bits_of(input int base);
    logic [L-1:0] v = '0;
    int a = int'(reg_addr);
    if (reg_wr && a >= base && a < base + 8 && a % 4 == 0)
      for (int i = 0; i < L; i++)
        if (i / 32 == (a - base) / 4) v[i] = reg_wdata[i % 32];
    return v;
  endfunction

  task automatic model_edge();
    logic [L-1:0] nrm, rec;
    bit fl;
    nrm = m_s2 ~^ m_pol;
    rec = nrm & ~m_nq & ~m_mask & ~m_sens;
    if (!(m_en && m_edge)) rec = '0;
    fl = reg_wr && reg_addr == 12'h300 && reg_wdata[2];
    m_flush = fl ? m_pend : '0;
    m_pend  = fl ? rec : (m_pend | rec);
    m_nq = nrm; m_s2 = m_s1; m_s1 = irq_in;
    m_mask = (m_mask | bits_of(32'h0C0)) & ~bits_of(32'h100);
    m_sens = (m_sens | bits_of(32'h180)) & ~bits_of(32'h1C0);
    m_pol  = (m_pol  | bits_of(32'h240)) & ~bits_of(32'h280);
    if (reg_wr && reg_addr == 12'h300) begin m_en = reg_wdata[0]; m_edge = reg_wdata[1]; end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, irq_out, m_en ? m_flush : (m_s2 ~^ m_pol));
    reg_wr = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(input string t, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s: read %h actual %h expected %h", t, a, reg_rdata, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    rd("R1", 12'h0C0, 32'hFFFF_FFFF); rd("R1", 12'h0C4, 32'h0000_00FF);
    rd("R1", 12'h180, 32'h0);          rd("R1", 12'h244, 32'h0000_00FF);
    rd("R1", 12'h300, 32'h0);
    // R4 transparent path, polarity 1
    tag = "R4";
    for (int i = 0; i < 20; i++) begin irq_in = {$urandom, $urandom}; step(); end
    wr(12'h280, 32'h0000_00F0); wr(12'h284, 32'h0000_0003);
    rd("R3", 12'h240, 32'hFFFF_FF0F); rd("R3", 12'h284, 32'h0000_00FC);
    for (int i = 0; i < 20; i++) begin irq_in = {$urandom, $urandom}; step(); end
    // R2 R3 mask and sensitivity banks
    tag = "R2";
    wr(12'h100, 32'h0000_FFFF); wr(12'h104, 32'h0000_00FF);
    rd("R3", 12'h0C0, 32'hFFFF_0000); rd("R3", 12'h104, 32'h0);
    wr(12'h0C0, 32'h0000_0008);
    rd("R2", 12'h100, 32'hFFFF_0008);
    wr(12'h180, 32'h0000_0F00);
    rd("R2", 12'h1C0, 32'h0000_0F00);
    // R5 R6 R7 directed recording
    irq_in = IDLE; repeat (4) step();
    tag = "R8";
    wr(12'h300, 32'h3);
    rd("R10", 12'h300, 32'h3);
    repeat (3) step();
    irq_in = IDLE | 40'h08_0010_0209; irq_in[4] = 1'b0;
    repeat (3) step();
    irq_in = IDLE; repeat (4) step();
    tag = "R9";
    wr(12'h300, 32'h7);
    chk("R5 R6 R7 R9 flushed lines", irq_out, 40'h08_0000_0011);
    rd("R10", 12'h300, 32'h3);
    step();
    chk("R9 pulse length", irq_out, '0);
    wr(12'h300, 32'h7);
    chk("R9 second flush", irq_out, '0);
    // R8 enable without edge mode
    tag = "R8";
    wr(12'h300, 32'h1);
    irq_in = IDLE | 40'h1; repeat (3) step(); irq_in = IDLE; repeat (3) step();
    wr(12'h300, 32'h7);
    chk("R8 enable only", irq_out, '0);
    // R8 edge mode without enable (transparent)
    wr(12'h300, 32'h2);
    irq_in = IDLE | 40'h1; repeat (3) step(); irq_in = IDLE; repeat (3) step();
    wr(12'h300, 32'h7);
    chk("R8 edge mode only", irq_out, '0);
    // random traffic while armed, then flush and disarm
    tag = "R5";
    wr(12'h300, 32'h3);
    for (int i = 0; i < 60; i++) begin irq_in = {$urandom, $urandom}; step(); end
    tag = "R9";
    wr(12'h300, 32'h7); repeat (3) step();
    tag = "R4";
    wr(12'h300, 32'h0);
    for (int i = 0; i < 10; i++) begin irq_in = {$urandom, $urandom}; step(); end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule